// File: doc/BRIEF.md
# Prescaled Interrupt Timer with Selectable Clock Event

This block is an interrupt timer for a cartridge on a retro console bus. An 8-bit prescaler drives an 8-bit main counter. Both step in the same direction, up or down, and the direction comes from a mode byte. The prescaler advances on one clock event chosen from four strobes: a CPU cycle, a PPU A12 rising edge, a PPU read whose address differs from the previous read, or a CPU write. Each time the prescaler rolls over, the main counter takes one step. When the main counter rolls over while the timer is enabled, the block latches a level interrupt request.

Software programs the block through eight byte-wide registers, selected by the low three address bits of a write. Prescaler and counter loads are XORed with a key register before they are stored. The prescaler can be narrowed so that only its low 3 bits take part in the rollover test. An interrupt stays asserted until software acknowledges it with a disable write.

Top module: `irq_tick_timer`

## Requirements
- R1: After reset `irq` is 0, the timer is disabled, the mode is stopped (direction 00, source 0), and the key is 0.
- R2: With mode bits [7:6] = 01, every selected tick increments the prescaler. When the prescaler's compared bits become all zero, the main counter increments. When the main counter increments to 0x00 while enabled, `irq` goes to 1 at the same clock edge.
- R3: Mode bit 2 = 1 restricts the prescaler rollover test to bits [2:0]. Mode bit 2 = 0 tests all 8 bits.
- R4: With mode bits [7:6] = 10, the prescaler decrements and clocks the main counter when its compared bits become all ones. The main counter decrements, and `irq` rises when it reaches 0xFF while enabled.
- R5: With mode bits [7:6] = 00 or 11, neither the prescaler nor the main counter changes on any event.
- R6: Mode bits [1:0] select the event source: 0 = `ev_cpu_cycle`, 1 = `ev_a12_rise`, 2 = `ev_ppu_read`, 3 = `ev_cpu_write`. Strobes from unselected sources have no effect.
- R7: With source 2, a `ev_ppu_read` strobe whose `ppu_addr` differs from the address of the previous such strobe gives two prescaler ticks in one cycle. A strobe with the same address gives none. The stored address is 0 after reset.
- R8: A write to offset 6 stores a key. A write to offset 4 loads the prescaler, and a write to offset 5 loads the main counter, each with the data XORed with the key. A load cancels counting in that cycle.
- R9: A write to offset 0 sets enable from data bit 0, and when that bit is 0 it also clears `irq`. A write to offset 2 disables and clears `irq`. A write to offset 3 enables without clearing. A rollover while disabled does not raise `irq`, and enabling later does not raise it after the fact.
- R10: Once set, `irq` stays at 1 through further ticks and rollovers, and through writes to offsets 3 and 0 with data bit 0 = 1, until a clearing write or reset.
- R11: A write to offset 7 is accepted and changes neither the counting nor `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register offset |
| wr_data | input | 8 | Write data |
| ev_cpu_cycle | input | 1 | CPU cycle strobe (source 0) |
| ev_a12_rise | input | 1 | PPU A12 rising edge strobe (source 1) |
| ev_ppu_read | input | 1 | PPU read strobe (source 2) |
| ppu_addr | input | 14 | Address of the PPU read |
| ev_cpu_write | input | 1 | CPU write strobe (source 3) |
| irq | output | 1 | Level interrupt request |

## Verification
Counting up and counting down are each started from loads that put the rollover a known number of ticks away. The tick on which `irq` rises then tells whether the prescaler compares 3 bits or 8 bits, and whether the XOR key was applied to the load. For source selection, all the unselected strobes are fired together before the selected one, which shows that only the chosen source advances the timer. A sequence of PPU reads at a new address, the same address, and a new address again exercises the two-tick step: it is the only case where the prescaler crosses zero in the middle of a single cycle.

// File: rtl/irq_tmr_pkg.sv
package irq_tmr_pkg;

  typedef enum logic [1:0] {
    SRC_CPU_CYC = 2'd0,
    SRC_A12     = 2'd1,
    SRC_PPU_RD  = 2'd2,
    SRC_CPU_WR  = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    DIR_STOP0 = 2'd0,
    DIR_UP    = 2'd1,
    DIR_DOWN  = 2'd2,
    DIR_STOP3 = 2'd3
  } dir_e;

  typedef struct packed {
    dir_e dir;
    logic narrow;
    src_e src;
  } mode_t;

  localparam logic [2:0] OFS_ENA     = 3'd0;
  localparam logic [2:0] OFS_MODE    = 3'd1;
  localparam logic [2:0] OFS_DIS     = 3'd2;
  localparam logic [2:0] OFS_EN_ONLY = 3'd3;
  localparam logic [2:0] OFS_PRE     = 3'd4;
  localparam logic [2:0] OFS_MAIN    = 3'd5;
  localparam logic [2:0] OFS_KEY     = 3'd6;
  localparam logic [2:0] OFS_SIZE    = 3'd7;

  localparam int MAX_TICKS = 2;
  localparam int TICK_W    = $clog2(MAX_TICKS + 1);

endpackage

// File: rtl/irq_tmr_regs.sv
module irq_tmr_regs
  import irq_tmr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output mode_t         mode,
  output logic          en,
  output logic          irq_clr,
  output logic          pre_ld,
  output logic          main_ld,
  output logic [DW-1:0] ld_val
);

  mode_t         mode_q, mode_d;
  logic [DW-1:0] key_q, key_d;
  logic          en_q, en_d;
  logic          reg_we;

  always_comb begin
    mode_d = mode_q;
    key_d  = key_q;
    en_d   = en_q;
    if (wr_en) begin
      case (wr_addr)
        OFS_ENA:     en_d = wr_data[0];
        OFS_MODE:    mode_d = '{dir: dir_e'(wr_data[7:6]), narrow: wr_data[2], src: src_e'(wr_data[1:0])};
        OFS_DIS:     en_d = 1'b0;
        OFS_EN_ONLY: en_d = 1'b1;
        OFS_KEY:     key_d = wr_data;
        default:     ;
      endcase
    end
  end

  assign reg_we = wr_en && (wr_addr != OFS_SIZE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '{dir: DIR_STOP0, narrow: 1'b0, src: SRC_CPU_CYC};
      key_q  <= '0;
      en_q   <= 1'b0;
    end else if (reg_we) begin
      mode_q <= mode_d;
      key_q  <= key_d;
      en_q   <= en_d;
    end
  end

  assign mode    = mode_q;
  assign en      = en_q;
  assign ld_val  = wr_data ^ key_q;
  assign pre_ld  = wr_en && (wr_addr == OFS_PRE);
  assign main_ld = wr_en && (wr_addr == OFS_MAIN);
  assign irq_clr = wr_en && ((wr_addr == OFS_DIS) || ((wr_addr == OFS_ENA) && !wr_data[0]));

  // R9
  en_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFS_EN_ONLY) |=> en);

  // R8
  key_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFS_KEY) |=> (ld_val == (wr_data ^ $past(wr_data))));

endmodule

// File: rtl/irq_tmr_event_sel.sv
module irq_tmr_event_sel
  import irq_tmr_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  src_e              src,
  input  logic              ev_cpu_cycle,
  input  logic              ev_a12_rise,
  input  logic              ev_ppu_read,
  input  logic [AW-1:0]     ppu_addr,
  input  logic              ev_cpu_write,
  output logic [TICK_W-1:0] ticks
);

  logic [AW-1:0] last_q, last_d;
  logic          rd_sel;

  assign rd_sel = (src == SRC_PPU_RD) && ev_ppu_read;

  always_comb begin
    last_d = last_q;
    if (rd_sel) last_d = ppu_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else if (rd_sel) last_q <= last_d;
  end

  always_comb begin
    ticks = '0;
    case (src)
      SRC_CPU_CYC: ticks = TICK_W'(ev_cpu_cycle);
      SRC_A12:     ticks = TICK_W'(ev_a12_rise);
      SRC_PPU_RD:  ticks = (rd_sel && (ppu_addr != last_q)) ? TICK_W'(MAX_TICKS) : '0;
      SRC_CPU_WR:  ticks = TICK_W'(ev_cpu_write);
      default:     ticks = '0;
    endcase
  end

  // R7
  rd_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel |=> (last_q == $past(ppu_addr)));

  // R6
  single_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src != SRC_PPU_RD) |-> (ticks <= TICK_W'(1)));

endmodule

// File: rtl/irq_tmr_counter.sv
module irq_tmr_counter
  import irq_tmr_pkg::*;
#(
  parameter int W        = 8,
  parameter int NARROW_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dir_e              dir,
  input  logic              narrow,
  input  logic [TICK_W-1:0] ticks,
  input  logic              pre_ld,
  input  logic              main_ld,
  input  logic [W-1:0]      ld_val,
  output logic              wrap
);

  localparam logic [W-1:0] ONE       = W'(1);
  localparam logic [W-1:0] NARROW_MK = W'((1 << NARROW_W) - 1);

  logic [W-1:0]         pre_q, main_q, pre_d, main_d;
  logic [W-1:0]         pre_c  [MAX_TICKS+1];
  logic [W-1:0]         main_c [MAX_TICKS+1];
  logic [MAX_TICKS-1:0] hit_w;
  logic [W-1:0]         mask;
  logic                 up, counting, any_ld;

  assign up       = (dir == DIR_UP);
  assign counting = (dir == DIR_UP) || (dir == DIR_DOWN);
  assign any_ld   = pre_ld || main_ld;
  assign mask     = narrow ? NARROW_MK : '1;
  assign pre_c[0]  = pre_q;
  assign main_c[0] = main_q;

  for (genvar i = 0; i < MAX_TICKS; i++) begin : g_step
    logic         act, roll;
    logic [W-1:0] pn, mn;
    assign act  = counting && !any_ld && (ticks > TICK_W'(i));
    assign pn   = up ? (pre_c[i] + ONE) : (pre_c[i] - ONE);
    assign roll = up ? ((pn & mask) == '0) : ((pn & mask) == mask);
    assign mn   = up ? (main_c[i] + ONE) : (main_c[i] - ONE);
    assign pre_c[i+1]  = act ? pn : pre_c[i];
    assign main_c[i+1] = (act && roll) ? mn : main_c[i];
    assign hit_w[i]    = act && roll && (up ? (mn == '0) : (mn == '1));
  end

  always_comb begin
    pre_d  = pre_c[MAX_TICKS];
    main_d = main_c[MAX_TICKS];
    if (pre_ld)  pre_d  = ld_val;
    if (main_ld) main_d = ld_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      main_q <= '0;
    end else begin
      pre_q  <= pre_d;
      main_q <= main_d;
    end
  end

  assign wrap = |hit_w;

  // R5
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!counting && !any_ld) |=> ($stable(pre_q) && $stable(main_q)));

  // R8
  main_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_ld |=> (main_q == $past(ld_val)));

  // R2
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && up) |=> (main_q == '0));

endmodule

// File: rtl/irq_tick_timer.sv
module irq_tick_timer
  import irq_tmr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic        ev_cpu_cycle,
  input  logic        ev_a12_rise,
  input  logic        ev_ppu_read,
  input  logic [13:0] ppu_addr,
  input  logic        ev_cpu_write,
  output logic        irq
);

  localparam int DW = 8;
  localparam int AW = 14;

  mode_t              mode;
  logic               en, irq_clr, pre_ld, main_ld, wrap;
  logic [DW-1:0]      ld_val;
  logic [TICK_W-1:0]  ticks;
  logic               irq_q, irq_d;

  irq_tmr_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode(mode), .en(en), .irq_clr(irq_clr), .pre_ld(pre_ld), .main_ld(main_ld),
    .ld_val(ld_val)
  );

  irq_tmr_event_sel #(.AW(AW)) u_evsel (
    .clk(clk), .rst_n(rst_n), .src(mode.src), .ev_cpu_cycle(ev_cpu_cycle),
    .ev_a12_rise(ev_a12_rise), .ev_ppu_read(ev_ppu_read), .ppu_addr(ppu_addr),
    .ev_cpu_write(ev_cpu_write), .ticks(ticks)
  );

  irq_tmr_counter #(.W(DW), .NARROW_W(3)) u_cnt (
    .clk(clk), .rst_n(rst_n), .dir(mode.dir), .narrow(mode.narrow), .ticks(ticks),
    .pre_ld(pre_ld), .main_ld(main_ld), .ld_val(ld_val), .wrap(wrap)
  );

  always_comb begin
    irq_d = irq_q;
    if (irq_clr)         irq_d = 1'b0;
    else if (wrap && en) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> !irq);

  // R10
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  // R9
  gated_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(en));

endmodule

// File: tb/irq_tick_timer_bench.sv
`timescale 1ns/1ps
module irq_tick_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        ev_cpu_cycle = 1'b0;
  logic        ev_a12_rise = 1'b0;
  logic        ev_ppu_read = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic        ev_cpu_write = 1'b0;
  logic        irq;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic  exp;
    string req;
    int    due;
  } item_t;

  item_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_tick_timer u_irq_tick_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ev_cpu_cycle(ev_cpu_cycle), .ev_a12_rise(ev_a12_rise), .ev_ppu_read(ev_ppu_read),
    .ppu_addr(ppu_addr), .ev_cpu_write(ev_cpu_write), .irq(irq)
  );

  // monitor: pops the scoreboard item due this cycle and compares
  always @(negedge clk) begin
    #1;
    if (sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      it = sb.pop_front();
      tests++;
      if (irq !== it.exp) begin
        fails++;
        $display("FAIL %s: irq=%b expected %b (cycle %0d)", it.req, irq, it.exp, cyc);
      end
    end
  end

  // driver: one cycle of stimulus, pushes the irq value expected after the edge
  task automatic drive(input logic we, input logic [2:0] a, input logic [7:0] d,
                       input logic cc, input logic a12, input logic rd,
                       input logic [13:0] ra, input logic cw,
                       input logic exp, input string req);
    item_t it;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d;
    ev_cpu_cycle = cc; ev_a12_rise = a12; ev_ppu_read = rd;
    ppu_addr = ra; ev_cpu_write = cw;
    it.exp = exp; it.req = req; it.due = cyc + 1;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic exp, input string req);
    drive(1'b1, a, d, 1'b0, 1'b0, 1'b0, 14'h0, 1'b0, exp, req);
  endtask

  task automatic idle(input logic exp, input string req);
    drive(1'b0, 3'd0, 8'h0, 1'b0, 1'b0, 1'b0, 14'h0, 1'b0, exp, req);
  endtask

  // n strobes on source s; expectation changes to exp_last on the final one
  task automatic pulses(input int s, input int n, input logic exp_mid,
                        input logic exp_last, input string req);
    for (int k = 0; k < n; k++) begin
      logic e;
      e = (k == n - 1) ? exp_last : exp_mid;
      drive(1'b0, 3'd0, 8'h0, s == 0, s == 1, s == 2, 14'h0, s == 3, e, req);
    end
  endtask

  task automatic setup(input logic [7:0] mode, input logic [7:0] pre, input logic [7:0] mn,
                       input string req);
    wr(3'd2, 8'h00, 1'b0, req);
    wr(3'd1, mode, 1'b0, req);
    wr(3'd4, pre, 1'b0, req);
    wr(3'd5, mn, 1'b0, req);
    wr(3'd3, 8'h00, 1'b0, req);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, idle cycles keep irq low
    idle(1'b0, "R1"); idle(1'b0, "R1");
    pulses(0, 4, 1'b0, 1'b0, "R1");

    // R2: up count, full-width prescaler, CPU cycle source
    wr(3'd6, 8'h00, 1'b0, "R2");
    setup(8'h40, 8'hFE, 8'hFF, "R2");
    pulses(0, 2, 1'b0, 1'b1, "R2");

    // R10: stays set through more ticks and non-clearing writes
    pulses(0, 3, 1'b1, 1'b1, "R10");
    wr(3'd3, 8'h00, 1'b1, "R10");
    wr(3'd0, 8'h01, 1'b1, "R10");
    // R9: offset 0 with bit0 = 0 clears and disables
    wr(3'd0, 8'h00, 1'b0, "R9");
    // R9: rollover while disabled raises nothing, late enable raises nothing
    wr(3'd4, 8'hFE, 1'b0, "R9");
    wr(3'd5, 8'hFF, 1'b0, "R9");
    pulses(0, 2, 1'b0, 1'b0, "R9");
    wr(3'd3, 8'h00, 1'b0, "R9");
    idle(1'b0, "R9");

    // R3: 3-bit prescaler, load 0x01 -> 7 ticks to rollover
    setup(8'h44, 8'h01, 8'hFF, "R3");
    pulses(0, 7, 1'b0, 1'b1, "R3");

    // R4: down count, pre 0x01 -> 0x00 -> 0xFF, main 0x00 -> 0xFF
    setup(8'h80, 8'h01, 8'h00, "R4");
    pulses(0, 2, 1'b0, 1'b1, "R4");

    // R5: stopped modes hold state
    setup(8'hC0, 8'hFE, 8'hFF, "R5");
    pulses(0, 10, 1'b0, 1'b0, "R5");
    wr(3'd1, 8'h00, 1'b0, "R5");
    pulses(0, 3, 1'b0, 1'b0, "R5");
    wr(3'd1, 8'h40, 1'b0, "R5");
    pulses(0, 2, 1'b0, 1'b1, "R5");

    // R6: A12 source ignores the other strobes
    setup(8'h41, 8'hFE, 8'hFF, "R6");
    for (int k = 0; k < 3; k++)
      drive(1'b0, 3'd0, 8'h0, 1'b1, 1'b0, 1'b1, 14'h200, 1'b1, 1'b0, "R6");
    pulses(1, 2, 1'b0, 1'b1, "R6");
    // R6: CPU write source ignores the other strobes
    setup(8'h43, 8'hFE, 8'hFF, "R6");
    for (int k = 0; k < 3; k++)
      drive(1'b0, 3'd0, 8'h0, 1'b1, 1'b1, 1'b1, 14'h201, 1'b0, 1'b0, "R6");
    pulses(3, 2, 1'b0, 1'b1, "R6");

    // R7: new address = 2 ticks, repeat address = none
    setup(8'h42, 8'hFD, 8'hFF, "R7");
    drive(1'b0, 3'd0, 8'h0, 1'b0, 1'b0, 1'b1, 14'h123, 1'b0, 1'b0, "R7");
    drive(1'b0, 3'd0, 8'h0, 1'b0, 1'b0, 1'b1, 14'h123, 1'b0, 1'b0, "R7");
    drive(1'b0, 3'd0, 8'h0, 1'b0, 1'b0, 1'b1, 14'h124, 1'b0, 1'b1, "R7");

    // R8: loads are XORed with the key (0x5A)
    wr(3'd6, 8'h5A, 1'b1, "R8");
    setup(8'h40, 8'hA4, 8'hA5, "R8");
    pulses(0, 2, 1'b0, 1'b1, "R8");

    // R11: offset 7 write has no effect; enable via offset 0 bit0 = 1 (R9)
    wr(3'd2, 8'h00, 1'b0, "R11");
    wr(3'd6, 8'h00, 1'b0, "R11");
    wr(3'd4, 8'hFC, 1'b0, "R11");
    wr(3'd5, 8'hFF, 1'b0, "R11");
    wr(3'd0, 8'h01, 1'b0, "R9");
    pulses(0, 2, 1'b0, 1'b0, "R11");
    wr(3'd7, 8'hFF, 1'b0, "R11");
    pulses(0, 2, 1'b0, 1'b1, "R11");

    idle(1'b1, "R10");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule